// File: doc/BRIEF.md
# Shared Storage Port Arbiter

This block selects which of three buses is served by one shared storage unit: two processor buses and one I/O bus that carries channel traffic. Each bus presents a request with an address, write data, a write flag and a test-and-set flag. The arbiter hands the storage to exactly one bus for one storage cycle. At the end of that cycle it returns the read byte together with a one-clock acknowledge on that bus's lane. Between storage cycles, no bus holds the storage.

I/O traffic always wins. When both processors contend, a one-bit turn pointer decides, and the loser is served in the very next storage cycle. A test-and-set reads a byte, forces its top bit to one and returns the old byte, all inside one storage cycle, so no other bus can reach that byte in between. Each processor bus has an availability line that models a manual partition switch. A request from a bus that is switched off is answered at once with an invalid-address indication and never reaches the storage.

The controller is a three-state machine. IDLE waits for an eligible request. The start transition (IDLE to ACCESS) latches the winner and its operands. ACCESS runs for a fixed number of clocks. The cycle-end transition (ACCESS to ACK) fires on its last clock. ACK drives the acknowledge for one clock, and the release transition (ACK to IDLE) follows unconditionally.

Top module: `sarb_top`

## Requirements
- R1: At most one bus receives a granted acknowledge (ack bit set with no invalid indication) in any clock, and that acknowledge lasts exactly one clock. Lane index 0 is processor A, 1 is processor B and 2 is I/O. Addresses and write data are packed with lane i at bits [i*W +: W].
- R2: A storage cycle lasts CYC_CLKS clocks. A request seen while the unit is idle is acknowledged CYC_CLKS+1 clocks later. The next grant is issued no earlier than CYC_CLKS+2 clocks after the previous one.
- R3: A pending I/O request is granted before any pending processor request.
- R4: When both processors request and I/O does not, the turn pointer picks the winner (0 selects processor A) and then flips. The pointer does not change on any other grant. After reset it selects processor A.
- R5: A test-and-set returns the old byte and leaves the byte with bit 7 set to one. Bit 7 of the returned byte is the condition code: 0 if the byte was clear, 1 if it was set.
- R6: A processor request made while that bus's availability line is low is acknowledged one clock later with the invalid indication set. It never starts a storage cycle and leaves storage unchanged.
- R7: A write stores its byte, and a later read from any bus returns it. The acknowledge of a write returns the byte's previous contents.
- R8: During and directly after reset, no acknowledge or invalid indication is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Request per lane, held until acknowledged |
| addr | input | 3*ADDR_W | Byte address per lane |
| wdata | input | 3*DATA_W | Write byte per lane |
| wr | input | 3 | Write flag per lane |
| tas | input | 3 | Test-and-set flag per lane |
| avail | input | 2 | Availability per processor lane |
| ack | output | 3 | One-clock acknowledge per lane |
| nack | output | 2 | Invalid-address indication per processor lane, valid with ack |
| rdata | output | DATA_W | Byte returned with a granted acknowledge |

## Verification
Every address of a small configuration is written from a rotating lane and then read back from a different lane. This tells a wrong lane or address mux apart from a correct store. Paired processor requests are issued in sequences where the pointer must flip, and one of them is preceded by a lone request that must not move the pointer, so a pointer that toggles on every grant is caught. Three-way requests and an I/O write colliding with a test-and-set on the same byte expose priority faults and broken atomicity through the returned values. Requests on switched-off buses are mixed with live ones to show that no storage change occurs and that the other bus is still served.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACCESS = 2'd1,
        S_ACK    = 2'd2
    } sarb_state_t;

    localparam int NREQ   = 3;
    localparam int NCPU   = 2;
    localparam int IO_IDX = 2;
endpackage

// File: rtl/sarb_pick.sv
module sarb_pick
    import sarb_pkg::*;
(
    input  logic [NREQ-1:0] elig,
    input  logic            turn,
    output logic [NREQ-1:0] win,
    output logic            contested
);
    always_comb begin
        contested = elig[0] & elig[1] & ~elig[IO_IDX];
        if (elig[IO_IDX]) begin
            win = 3'b100;
        end else if (contested) begin
            win = turn ? 3'b010 : 3'b001;
        end else begin
            win = {1'b0, elig[1:0]};
        end
    end
endmodule

// File: rtl/sarb_turn.sv
module sarb_turn (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic turn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn <= 1'b0;
        end else if (flip) begin
            turn <= ~turn;
        end
    end
endmodule

// File: rtl/sarb_ram.sv
module sarb_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] a,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            rd <= mem[a];
            if (we) begin
                mem[a] <= wd;
            end
        end
    end
endmodule

// File: rtl/sarb_top.sv
module sarb_top
    import sarb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int CYC_CLKS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               req,
    input  logic [3*ADDR_W-1:0]      addr,
    input  logic [3*DATA_W-1:0]      wdata,
    input  logic [2:0]               wr,
    input  logic [2:0]               tas,
    input  logic [1:0]               avail,
    output logic [2:0]               ack,
    output logic [1:0]               nack,
    output logic [DATA_W-1:0]        rdata
);
    localparam int              CNT_W = $clog2(CYC_CLKS) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_CLKS - 1);
    localparam logic [DATA_W-1:0] TOP_BIT = DATA_W'(1) << (DATA_W - 1);

    sarb_state_t state_q, state_d;

    logic [CNT_W-1:0]  cnt_q;
    logic [NREQ-1:0]   gsel_q;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] wd_q;
    logic              we_q;
    logic              tas_q;
    logic [DATA_W-1:0] rd_q;
    logic [NCPU-1:0]   rej_q;

    logic [NREQ-1:0]   elig;
    logic [NREQ-1:0]   win;
    logic              contested;
    logic              turn;
    logic              start;
    logic [NREQ-1:0]   inflight;

    logic [ADDR_W-1:0] sel_a;
    logic [DATA_W-1:0] sel_d;
    logic              sel_we;
    logic              sel_tas;

    logic              ram_en;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wd;
    logic [DATA_W-1:0] ram_rd;

    assign elig     = req & {1'b1, avail};
    assign start    = (state_q == S_IDLE) && (|elig);
    assign inflight = (state_q != S_IDLE) ? gsel_q : '0;

    sarb_pick u_pick (
        .elig      (elig),
        .turn      (turn),
        .win       (win),
        .contested (contested)
    );

    sarb_turn u_turn (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (start & contested),
        .turn  (turn)
    );

    // operand mux driven by the one-hot winner
    always_comb begin
        sel_a   = '0;
        sel_d   = '0;
        sel_we  = 1'b0;
        sel_tas = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (win[i]) begin
                sel_a   = addr[i*ADDR_W +: ADDR_W];
                sel_d   = wdata[i*DATA_W +: DATA_W];
                sel_we  = wr[i];
                sel_tas = tas[i];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)         state_d = S_ACCESS;
            S_ACCESS: if (cnt_q == LAST) state_d = S_ACK;
            S_ACK:                       state_d = S_IDLE;
            default:                     state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            gsel_q <= '0;
            a_q    <= '0;
            wd_q   <= '0;
            we_q   <= 1'b0;
            tas_q  <= 1'b0;
            rd_q   <= '0;
            rej_q  <= '0;
        end else begin
            if (start) begin
                gsel_q <= win;
                a_q    <= sel_a;
                wd_q   <= sel_d;
                we_q   <= sel_we;
                tas_q  <= sel_tas;
            end
            if (state_q == S_ACCESS) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (state_q == S_ACCESS && cnt_q == CNT_W'(1)) begin
                rd_q <= ram_rd;
            end
            rej_q <= req[NCPU-1:0] & ~avail & ~rej_q & ~inflight[NCPU-1:0];
        end
    end

    // storage port control: access on the first clock, test-and-set write-back on the second
    always_comb begin
        ram_en = 1'b0;
        ram_we = 1'b0;
        ram_wd = wd_q;
        if (state_q == S_ACCESS) begin
            if (cnt_q == '0) begin
                ram_en = 1'b1;
                ram_we = we_q & ~tas_q;
            end else if (cnt_q == CNT_W'(1) && tas_q) begin
                ram_en = 1'b1;
                ram_we = 1'b1;
                ram_wd = ram_rd | TOP_BIT;
            end
        end
    end

    sarb_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk (clk),
        .en  (ram_en),
        .we  (ram_we),
        .a   (a_q),
        .wd  (ram_wd),
        .rd  (ram_rd)
    );

    // outputs
    always_comb begin
        ack   = {1'b0, rej_q};
        nack  = rej_q;
        rdata = rd_q;
        unique case (state_q)
            S_ACK:   ack = gsel_q | {1'b0, rej_q};
            default: ack = {1'b0, rej_q};
        endcase
    end

    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack & ~{1'b0, nack}));
    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK) |=> (state_q == S_IDLE));
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCESS) |-> (cnt_q <= LAST));
    a_r2_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCESS && cnt_q != LAST) |=> (state_q == S_ACCESS && $stable(gsel_q)));
    a_r3_io_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req[IO_IDX]) |=> (gsel_q == 3'b100));
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req[0] && req[1] && avail[0] && avail[1] && !req[IO_IDX]) |=> (turn != $past(turn)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && contested) |=> $stable(turn));
    a_r6_off_a: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !avail[0]) |=> !gsel_q[0]);
    a_r6_off_b: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !avail[1]) |=> !gsel_q[1]);
endmodule

// File: tb/tb_sarb_top.sv
module tb_sarb_top;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int CYC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       req = '0;
    logic [3*AW-1:0]  addr = '0;
    logic [3*DW-1:0]  wdata = '0;
    logic [2:0]       wr = '0;
    logic [2:0]       tas = '0;
    logic [1:0]       avail = 2'b11;
    logic [2:0]       ack;
    logic [1:0]       nack;
    logic [DW-1:0]    rdata;

    always #4 clk = ~clk;

    sarb_top #(.ADDR_W(AW), .DATA_W(DW), .CYC_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
        .wr(wr), .tas(tas), .avail(avail), .ack(ack), .nack(nack), .rdata(rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] b_a   [3];
    logic [DW-1:0] b_d   [3];
    logic          b_we  [3];
    logic          b_tas [3];
    int            ord   [3];
    int            nord;
    logic [DW-1:0] got   [3];
    logic          gotn  [3];
    int            lat   [3];
    logic [DW-1:0] shadow [1 << AW];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic batch(logic [2:0] m);
        int t;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            addr[i*AW +: AW]  = b_a[i];
            wdata[i*DW +: DW] = b_d[i];
            wr[i]             = b_we[i];
            tas[i]            = b_tas[i];
            lat[i]            = -1;
        end
        nord = 0;
        t = 0;
        req = m;
        while (req != 3'b000 && t < 200) begin
            @(negedge clk);
            t++;
            for (int i = 0; i < 3; i++) begin
                if (req[i] && ack[i]) begin
                    ord[nord] = i;
                    nord++;
                    got[i]  = rdata;
                    gotn[i] = (i < 2) ? nack[i] : 1'b0;
                    lat[i]  = t;
                    req[i]  = 1'b0;
                end
            end
        end
        if (req != 3'b000) begin
            chk("R2 request never acknowledged", int'(req), 0);
            req = '0;
        end
    endtask

    task automatic set_op(int i, int a, int d, bit w, bit ts);
        b_a[i]   = AW'(a);
        b_d[i]   = DW'(d);
        b_we[i]  = w;
        b_tas[i] = ts;
    endtask

    task automatic rd_one(int i, int a, output logic [DW-1:0] v);
        set_op(i, a, 0, 1'b0, 1'b0);
        batch(3'(1 << i));
        v = got[i];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < 3; i++) set_op(i, 0, 0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 ack in reset", int'(ack), 0);
        chk("R8 nack in reset", int'(nack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ack after reset", int'(ack), 0);

        // R7 / R2: write every address from a rotating lane, single-request latency
        for (int a = 0; a < (1 << AW); a++) begin
            int w = a % 3;
            int d = (a * 37 + 5) & 8'hFF;
            set_op(w, a, d, 1'b1, 1'b0);
            batch(3'(1 << w));
            shadow[a] = DW'(d);
            chk("R2 single latency", lat[w], CYC + 1);
        end
        for (int a = 0; a < (1 << AW); a++) begin
            rd_one((a + 1) % 3, a, v);
            chk("R7 read back", int'(v), int'(shadow[a]));
        end

        // R7: write acknowledge carries the previous byte
        set_op(0, 3, 8'h5A, 1'b1, 1'b0);
        batch(3'b001);
        chk("R7 write returns old", int'(got[0]), int'(shadow[3]));
        shadow[3] = 8'h5A;

        // R4: contested pairs, pointer starts at A
        set_op(0, 1, 0, 1'b0, 1'b0);
        set_op(1, 2, 0, 1'b0, 1'b0);
        batch(3'b011);
        chk("R4 first contest A wins", ord[0], 0);
        chk("R4 loser next", ord[1], 1);
        chk("R2 grant spacing", lat[1] - lat[0], CYC + 2);
        chk("R4 data A", int'(got[0]), int'(shadow[1]));
        chk("R4 data B", int'(got[1]), int'(shadow[2]));
        batch(3'b011);
        chk("R4 second contest B wins", ord[0], 1);
        set_op(1, 4, 0, 1'b0, 1'b0);
        batch(3'b010);
        chk("R4 lone B data", int'(got[1]), int'(shadow[4]));
        set_op(1, 2, 0, 1'b0, 1'b0);
        batch(3'b011);
        chk("R4 lone grant keeps pointer", ord[0], 0);

        // R3: three-way, pointer now selects B
        set_op(2, 6, 0, 1'b0, 1'b0);
        batch(3'b111);
        chk("R3 io first", ord[0], 2);
        chk("R4 pointer after io", ord[1], 1);
        chk("R4 last A", ord[2], 0);
        chk("R3 io data", int'(got[2]), int'(shadow[6]));

        // R5: test-and-set
        set_op(0, 5, 8'h35, 1'b1, 1'b0);
        batch(3'b001);
        set_op(1, 5, 0, 1'b0, 1'b1);
        batch(3'b010);
        chk("R5 tas old byte", int'(got[1]), 8'h35);
        chk("R5 cc clear", int'(got[1][7]), 0);
        rd_one(2, 5, v);
        chk("R5 bit set", int'(v), 8'hB5);
        batch(3'b010);
        chk("R5 cc set", int'(got[1][7]), 1);
        chk("R5 second tas old", int'(got[1]), 8'hB5);
        set_op(2, 7, 8'h11, 1'b1, 1'b0);
        set_op(0, 7, 0, 1'b0, 1'b1);
        batch(3'b101);
        chk("R3 io before tas", ord[0], 2);
        chk("R5 tas sees io write", int'(got[0]), 8'h11);
        rd_one(1, 7, v);
        chk("R5 tas final", int'(v), 8'h91);
        shadow[5] = 8'hB5;
        shadow[7] = 8'h91;

        // R6: switched-off buses
        avail = 2'b10;
        set_op(0, 9, 8'hEE, 1'b1, 1'b0);
        batch(3'b001);
        chk("R6 nack A", int'(gotn[0]), 1);
        chk("R6 nack latency", lat[0], 1);
        rd_one(2, 9, v);
        chk("R6 store untouched", int'(v), int'(shadow[9]));
        set_op(1, 10, 0, 1'b0, 1'b0);
        batch(3'b011);
        chk("R6 off bus answered first", ord[0], 0);
        chk("R6 live bus valid", int'(gotn[1]), 0);
        chk("R6 live bus data", int'(got[1]), int'(shadow[10]));
        avail = 2'b01;
        set_op(1, 11, 0, 1'b0, 1'b1);
        batch(3'b010);
        chk("R6 nack B", int'(gotn[1]), 1);
        avail = 2'b11;
        rd_one(0, 11, v);
        chk("R6 tas blocked", int'(v), int'(shadow[11]));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule